// File: doc/BRIEF.md
# Branch Target Prediction Front End

This block supplies the fetch stage of a five-stage pipeline with a predicted next fetch address every cycle. It combines three structures. A direct-mapped target buffer holds branch targets. A table of two-bit saturating counters gives the branch direction, and it is read only when the target buffer hits. A circular return stack supplies the targets of return instructions. The block predicts combinationally from the current fetch PC and the predecode flags that mark a call or a return.

Branches and jumps resolve in the execute stage. That stage sends back the resolved outcome, the resolved target and the prediction that travelled down the pipe with the instruction. From these the block trains its tables and decides whether fetch must be redirected, and to which address.

Top module: `bpred_front`

## Requirements
- R1: After reset every target-buffer entry is invalid and the return stack is empty, so no non-return fetch is predicted taken and the predicted PC is fetch PC + 4.
- R2: A non-return fetch whose PC misses the target buffer gives pred_taken_o = 0 and pred_pc_o = fetch PC + 4. The buffer index is PC[5:2] and the tag is PC[31:6].
- R3: A non-return fetch that hits the buffer is predicted taken exactly when bit 1 of its direction counter is set. When taken, pred_pc_o is the stored target. Otherwise it is PC + 4.
- R4: A fetch flagged as a return ignores the target buffer. When the return stack holds entries it predicts taken to the top entry. When the stack is empty it predicts not taken with PC + 4.
- R5: A valid call fetch pushes its PC + 4 onto an 8-entry return stack, and a valid return fetch pops it. A push onto a full stack overwrites the oldest entry. A pop on an empty stack leaves the stack unchanged.
- R6: A resolved taken branch that misses the buffer allocates the entry with its tag and target and sets the counter to weakly-taken (2'b10). A resolved not-taken branch that misses allocates nothing.
- R7: A resolved branch that hits moves its counter up on taken and down on not-taken, saturating at 2'b00 and 2'b11. A taken outcome also rewrites the stored target.
- R8: mispredict_o is high for a valid resolved instruction when the resolved direction differs from the carried prediction, or when the instruction is taken and its target differs from the carried predicted PC. redirect_pc_o is the resolved target when taken, else the resolved PC + 4.
- R9: The tables are trained only when ex_valid_i and ex_branch_i are both high. A resolved return or other non-branch leaves the target buffer and counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch slot holds a real instruction |
| fetch_pc_i | input | 32 | Current fetch PC |
| fetch_call_i | input | 1 | Predecode: instruction is a call |
| fetch_ret_i | input | 1 | Predecode: instruction is a return |
| pred_pc_o | output | 32 | Predicted next fetch PC |
| pred_taken_o | output | 1 | Prediction is taken |
| ex_valid_i | input | 1 | Execute stage holds a resolved control instruction |
| ex_branch_i | input | 1 | Resolved instruction is a branch or jump (not a return) |
| ex_pc_i | input | 32 | PC of the resolved instruction |
| ex_taken_i | input | 1 | Resolved direction |
| ex_target_i | input | 32 | Resolved target |
| ex_pred_taken_i | input | 1 | Direction predicted at fetch, carried down the pipe |
| ex_pred_pc_i | input | 32 | Next PC predicted at fetch, carried down the pipe |
| mispredict_o | output | 1 | Fetch must be redirected |
| redirect_pc_o | output | 32 | Address to fetch from on a redirect |

## Verification
The assertions assume that a fetch is never flagged as both a call and a return in the same cycle. The stimulus picks a single fetch kind per cycle, so the two flags never rise together. The assertions also assume word-aligned PCs. Both fetch and execute PCs are drawn from a small pool of aligned addresses that share two tags across sixteen indexes, so hits, tag conflicts and re-allocations happen often. Directed runs before the random phase cover an empty-stack return, allocation on a taken miss, counter decay to zero, stack overflow with nine calls, and a resolved return that must not train the tables.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;
endpackage

// File: rtl/bpred_btb.sv
module bpred_btb #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] rd_pc_i,
  output logic            rd_hit_o,
  output logic [PC_W-1:0] rd_tgt_o,
  input  logic            up_en_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic            up_taken_i,
  input  logic [PC_W-1:0] up_tgt_i,
  output logic            up_hit_o
);
  localparam int N     = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [N-1:0]      vld_q;
  logic [TAG_W-1:0]  tag_q [N];
  logic [PC_W-1:0]   tgt_q [N];

  logic [IDX_W-1:0]  rd_idx, up_idx;
  logic [TAG_W-1:0]  rd_tag, up_tag;
  logic              unused_lsb;

  assign rd_idx     = rd_pc_i[IDX_W+1:2];
  assign rd_tag     = rd_pc_i[PC_W-1:IDX_W+2];
  assign up_idx     = up_pc_i[IDX_W+1:2];
  assign up_tag     = up_pc_i[PC_W-1:IDX_W+2];
  assign unused_lsb = ^{rd_pc_i[1:0], up_pc_i[1:0]};

  assign rd_hit_o = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_tgt_o = tgt_q[rd_idx];
  assign up_hit_o = vld_q[up_idx] && (tag_q[up_idx] == up_tag);

  // taken outcome both allocates on a miss and refreshes the target on a hit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (up_en_i && up_taken_i) begin
      vld_q[up_idx] <= 1'b1;
      tag_q[up_idx] <= up_tag;
      tgt_q[up_idx] <= up_tgt_i;
    end
  end

  p_alloc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_en_i && up_taken_i) |=> (vld_q[$past(up_idx)] && tag_q[$past(up_idx)] == $past(up_tag)
                                 && tgt_q[$past(up_idx)] == $past(up_tgt_i)));

  p_nt_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_en_i && !up_taken_i) |=> $stable(vld_q));
endmodule

// File: rtl/bpred_pht.sv
module bpred_pht
  import bpred_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             up_en_i,
  input  logic [IDX_W-1:0] up_idx_i,
  input  logic             up_hit_i,
  input  logic             up_taken_i
);
  localparam int N = 1 << IDX_W;

  ctr_t ctr_q [N];

  assign rd_ctr_o = ctr_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) ctr_q[i] <= CTR_WNT;
    end else if (up_en_i) begin
      if (!up_hit_i) begin
        if (up_taken_i) ctr_q[up_idx_i] <= CTR_WT;
      end else if (up_taken_i) begin
        if (ctr_q[up_idx_i] != CTR_ST) ctr_q[up_idx_i] <= ctr_q[up_idx_i] + 2'd1;
      end else begin
        if (ctr_q[up_idx_i] != CTR_SNT) ctr_q[up_idx_i] <= ctr_q[up_idx_i] - 2'd1;
      end
    end
  end

  p_alloc_wt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_en_i && !up_hit_i && up_taken_i) |=> (ctr_q[$past(up_idx_i)] == CTR_WT));

  p_sat_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_en_i && up_hit_i && up_taken_i && ctr_q[up_idx_i] == CTR_ST)
      |=> (ctr_q[$past(up_idx_i)] == CTR_ST));

  p_sat_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_en_i && up_hit_i && !up_taken_i && ctr_q[up_idx_i] == CTR_SNT)
      |=> (ctr_q[$past(up_idx_i)] == CTR_SNT));
endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [PC_W-1:0] push_val_i,
  input  logic            pop_i,
  output logic [PC_W-1:0] top_o,
  output logic            empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] sp_q;
  logic [CNT_W-1:0] cnt_q;

  // circular: a push on a full stack lands on the oldest slot
  assign top_o   = mem_q[sp_q - PTR_W'(1)];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[sp_q] <= push_val_i;
      sp_q        <= sp_q + PTR_W'(1);
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      sp_q  <= sp_q - PTR_W'(1);
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  p_push_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (top_o == $past(push_val_i) && !empty_o));

  p_empty_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o);
endmodule

// File: rtl/bpred_front.sv
module bpred_front
  import bpred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 4,
  parameter int RAS_DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_valid_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            fetch_call_i,
  input  logic            fetch_ret_i,
  output logic [PC_W-1:0] pred_pc_o,
  output logic            pred_taken_o,
  input  logic            ex_valid_i,
  input  logic            ex_branch_i,
  input  logic [PC_W-1:0] ex_pc_i,
  input  logic            ex_taken_i,
  input  logic [PC_W-1:0] ex_target_i,
  input  logic            ex_pred_taken_i,
  input  logic [PC_W-1:0] ex_pred_pc_i,
  output logic            mispredict_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  logic            btb_hit, up_hit, up_en, ras_empty;
  logic [PC_W-1:0] btb_tgt, ras_top, fetch_seq;
  ctr_t            ctr;

  assign up_en     = ex_valid_i && ex_branch_i;
  assign fetch_seq = fetch_pc_i + PC_W'(4);

  bpred_btb #(.PC_W(PC_W), .IDX_W(IDX_W)) u_btb (
    .clk_i, .rst_ni,
    .rd_pc_i   (fetch_pc_i),
    .rd_hit_o  (btb_hit),
    .rd_tgt_o  (btb_tgt),
    .up_en_i   (up_en),
    .up_pc_i   (ex_pc_i),
    .up_taken_i(ex_taken_i),
    .up_tgt_i  (ex_target_i),
    .up_hit_o  (up_hit)
  );

  bpred_pht #(.IDX_W(IDX_W)) u_pht (
    .clk_i, .rst_ni,
    .rd_idx_i  (fetch_pc_i[IDX_W+1:2]),
    .rd_ctr_o  (ctr),
    .up_en_i   (up_en),
    .up_idx_i  (ex_pc_i[IDX_W+1:2]),
    .up_hit_i  (up_hit),
    .up_taken_i(ex_taken_i)
  );

  bpred_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i, .rst_ni,
    .push_i    (fetch_valid_i && fetch_call_i),
    .push_val_i(fetch_seq),
    .pop_i     (fetch_valid_i && fetch_ret_i),
    .top_o     (ras_top),
    .empty_o   (ras_empty)
  );

  // direction counter is only meaningful behind a buffer hit
  always_comb begin
    pred_taken_o = 1'b0;
    pred_pc_o    = fetch_seq;
    if (fetch_ret_i) begin
      if (!ras_empty) begin
        pred_taken_o = 1'b1;
        pred_pc_o    = ras_top;
      end
    end else if (btb_hit && ctr[1]) begin
      pred_taken_o = 1'b1;
      pred_pc_o    = btb_tgt;
    end
  end

  assign mispredict_o  = ex_valid_i && ((ex_taken_i != ex_pred_taken_i) ||
                                        (ex_taken_i && (ex_target_i != ex_pred_pc_i)));
  assign redirect_pc_o = ex_taken_i ? ex_target_i : ex_pc_i + PC_W'(4);

  p_call_ret_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_valid_i && fetch_call_i && fetch_ret_i));

  p_redirect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mispredict_o && ex_taken_i) |-> (redirect_pc_o == ex_target_i));

  p_no_mp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && !mispredict_o && ex_taken_i) |-> (ex_pred_taken_i && ex_pred_pc_i == redirect_pc_o));

  p_ret_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_ret_i && ras_empty) |-> (!pred_taken_o && pred_pc_o == fetch_pc_i + PC_W'(4)));
endmodule

// File: tb/bpred_front_tb_top.sv
module bpred_front_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 16;
  localparam int D     = 8;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        fetch_valid = 0, fetch_call = 0, fetch_ret = 0;
  logic [31:0] fetch_pc = 0;
  logic [31:0] pred_pc;
  logic        pred_taken;
  logic        ex_valid = 0, ex_branch = 0, ex_taken = 0, ex_pred_taken = 0;
  logic [31:0] ex_pc = 0, ex_target = 0, ex_pred_pc = 0;
  logic        mispredict;
  logic [31:0] redirect_pc;

  bpred_front dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc),
    .fetch_call_i(fetch_call), .fetch_ret_i(fetch_ret),
    .pred_pc_o(pred_pc), .pred_taken_o(pred_taken),
    .ex_valid_i(ex_valid), .ex_branch_i(ex_branch), .ex_pc_i(ex_pc),
    .ex_taken_i(ex_taken), .ex_target_i(ex_target),
    .ex_pred_taken_i(ex_pred_taken), .ex_pred_pc_i(ex_pred_pc),
    .mispredict_o(mispredict), .redirect_pc_o(redirect_pc)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic        m_vld [N];
  logic [25:0] m_tag [N];
  logic [31:0] m_tgt [N];
  logic [1:0]  m_ctr [N];
  logic [31:0] m_ras [D];
  int          m_sp = 0, m_cnt = 0;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_pc(int unsigned r);
    return {25'h0, r[4], r[3:0], 2'b00};
  endfunction

  // call after driving inputs at a negedge
  task automatic cyc(string tag);
    int i, j;
    logic hit, et, emp, uh;
    logic [31:0] epc;
    string req;
    #1;
    i   = int'(fetch_pc[5:2]);
    hit = m_vld[i] && m_tag[i] == fetch_pc[31:6];
    et  = 1'b0;
    epc = fetch_pc + 4;
    if (fetch_ret) begin
      req = "R4";
      if (m_cnt > 0) begin et = 1'b1; epc = m_ras[(m_sp + D - 1) % D]; end
    end else if (hit) begin
      req = "R3";
      if (m_ctr[i][1]) begin et = 1'b1; epc = m_tgt[i]; end
    end else req = "R2";
    if (tag != "") req = tag;
    chk(req, "pred_taken", 32'(pred_taken), 32'(et));
    chk(req, "pred_pc", pred_pc, epc);
    emp = ex_valid && ((ex_taken != ex_pred_taken) || (ex_taken && ex_target != ex_pred_pc));
    chk("R8", "mispredict", 32'(mispredict), 32'(emp));
    chk("R8", "redirect_pc", redirect_pc, ex_taken ? ex_target : ex_pc + 4);
    @(posedge clk);
    if (ex_valid && ex_branch) begin
      j  = int'(ex_pc[5:2]);
      uh = m_vld[j] && m_tag[j] == ex_pc[31:6];
      if (!uh) begin
        if (ex_taken) begin
          m_vld[j] = 1; m_tag[j] = ex_pc[31:6]; m_tgt[j] = ex_target; m_ctr[j] = 2'b10;
        end
      end else if (ex_taken) begin
        if (m_ctr[j] != 2'b11) m_ctr[j] = m_ctr[j] + 1;
        m_tgt[j] = ex_target;
      end else if (m_ctr[j] != 2'b00) m_ctr[j] = m_ctr[j] - 1;
    end
    if (fetch_valid && fetch_call) begin
      m_ras[m_sp] = fetch_pc + 4;
      m_sp = (m_sp + 1) % D;
      if (m_cnt < D) m_cnt++;
    end else if (fetch_valid && fetch_ret && m_cnt > 0) begin
      m_sp = (m_sp + D - 1) % D;
      m_cnt--;
    end
  endtask

  task automatic idle_ex();
    ex_valid = 0; ex_branch = 0; ex_taken = 0; ex_pred_taken = 0;
    ex_pc = 0; ex_target = 0; ex_pred_pc = 4;
  endtask

  task automatic fetch(logic [31:0] pc, logic c, logic r);
    fetch_valid = 1; fetch_pc = pc; fetch_call = c; fetch_ret = r;
  endtask

  task automatic resolve(logic [31:0] pc, logic br, logic tk, logic [31:0] tgt);
    ex_valid = 1; ex_branch = br; ex_pc = pc; ex_taken = tk; ex_target = tgt;
    ex_pred_taken = 0; ex_pred_pc = pc + 4;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    for (int k = 0; k < N; k++) begin m_vld[k] = 0; m_tag[k] = 0; m_tgt[k] = 0; m_ctr[k] = 2'b01; end
    for (int k = 0; k < D; k++) m_ras[k] = 0;
    r = $urandom(32'h5EED_0042);
    idle_ex();
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: reset state across several PCs
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); fetch(32'h40 + 32'(k * 4), 0, 0); idle_ex(); cyc("R1");
    end
    // R4: return on an empty stack
    @(negedge clk); fetch(32'h80, 0, 1); cyc("R4");
    // R6: taken miss allocates, then fetch hits weakly-taken
    @(negedge clk); fetch(32'h10, 0, 0); resolve(32'h10, 1, 1, 32'h200); cyc("R6");
    @(negedge clk); fetch(32'h10, 0, 0); idle_ex(); cyc("R6");
    // R6: not-taken miss allocates nothing
    @(negedge clk); fetch(32'h14, 0, 0); resolve(32'h14, 1, 0, 32'h300); cyc("R6");
    @(negedge clk); fetch(32'h14, 0, 0); idle_ex(); cyc("R6");
    // R7: decay to zero, extra not-taken saturates, then one taken stays not-taken
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); fetch(32'h10, 0, 0); resolve(32'h10, 1, 0, 32'h0); cyc("R7");
    end
    @(negedge clk); fetch(32'h10, 0, 0); resolve(32'h10, 1, 1, 32'h240); cyc("R7");
    @(negedge clk); fetch(32'h10, 0, 0); idle_ex(); cyc("R7");
    // R7: saturate high
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); fetch(32'h10, 0, 0); resolve(32'h10, 1, 1, 32'h280); cyc("R7");
    end
    @(negedge clk); fetch(32'h10, 0, 0); resolve(32'h10, 1, 0, 32'h0); cyc("R7");
    @(negedge clk); fetch(32'h10, 0, 0); idle_ex(); cyc("R7");
    // R9: resolved return trains nothing
    @(negedge clk); fetch(32'h20, 0, 0); resolve(32'h20, 0, 1, 32'h400); cyc("R9");
    @(negedge clk); fetch(32'h20, 0, 0); idle_ex(); cyc("R9");
    // R5: nine calls overflow, then ten returns
    for (int k = 0; k < 9; k++) begin
      @(negedge clk); fetch(32'h1000 + 32'(k * 16), 1, 0); cyc("R5");
    end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); fetch(32'h2000, 0, 1); cyc("R5");
    end
    // R5: invalid fetch slot does not push
    @(negedge clk); fetch(32'h3000, 1, 0); fetch_valid = 0; cyc("R5");
    @(negedge clk); fetch(32'h2000, 0, 1); cyc("R5");

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      r = $urandom;
      fetch_valid = (r[2:0] != 0);
      fetch_pc    = mk_pc($urandom);
      fetch_call  = (r[5:3] == 0);
      fetch_ret   = (r[5:3] == 1);
      ex_valid    = (r[7:6] != 0);
      ex_branch   = (r[9:8] != 0);
      ex_pc       = mk_pc($urandom);
      ex_taken    = r[10];
      ex_target   = $urandom & 32'hFFFF_FFFC;
      ex_pred_taken = r[11];
      ex_pred_pc  = r[12] ? ex_target : ($urandom & 32'hFFFF_FFFC);
      cyc("");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule